// File: doc/BRIEF.md
# Dual-Issue Pair Hazard Checker

This block is the issue-stage control of a statically scheduled, two-wide, in-order pipeline. Every cycle the fetch side may offer a packet of up to two instruction descriptors, slot 0 being older in program order. A well-formed packet pairs one floating-point arithmetic operation with one operation from the integer side: an integer ALU op, a load, a store, a branch, or a floating-point load, store or register move. The block decides how many of the offered instructions leave for the functional units in the current cycle, always in program order.

The decision is spread over two registered stages. The first stage holds the fetched packet and settles whether its two members may leave together. The second stage compares the registers each member reads and writes against a scoreboard of destinations still in flight, where each entry counts down the cycles until its value is usable. An instruction left behind by a partial issue moves to the older slot and is offered again the next cycle. While the second stage holds work, the first stage keeps its packet and asks fetch to wait.

Top module: `pair_issue_ctrl`

## Requirements
- R1: A descriptor is {kind[2:0], dst[5:0], srcA[5:0], srcB[5:0]} with dst in bits 17:12. The kind codes are 0 integer ALU (reads A and B, writes dst), 1 load (reads A, writes dst), 2 store (reads A and B), 3 branch (reads A and B), 4 floating-point arithmetic (reads A and B, writes dst), 5 floating-point load (reads A, writes dst), 6 floating-point store (reads A and B) and 7 floating-point move (reads A, writes dst). Register indices 0 to 31 are integer registers and 32 to 63 are floating-point registers, all in one index space.
- R2: A packet accepted at a clock edge, with no hazard, is issued two cycles later. When both members are free to go, issue_vld is 2'b11 and issue_cnt is 2.
- R3: A packet with only slot 0 valid issues that one instruction. A packet with only slot 1 valid is compacted into slot 0 and shows on issue_ins0.
- R4: Two members that are both floating-point arithmetic, or both of the integer side, never issue in the same cycle. Slot 0 issues first and slot 1 issues in a later cycle.
- R5: When the integer-side member is a floating-point load, store or move, it competes for the floating-point register ports. The pair is split and slot 0 issues alone.
- R6: If slot 1 reads a register that slot 0 writes (RAW), or writes the same register (WAW), the pair is split.
- R7: An instruction that reads the destination of a load (kind 1 or 5) issues no earlier than two cycles after the load.
- R8: An instruction that reads the destination of a floating-point arithmetic op issues no earlier than three cycles after it.
- R9: An instruction whose destination is still pending from an older in-flight write waits until that write is complete.
- R10: Issue is in order. Slot 1 never issues in a cycle in which slot 0 of the same stage is blocked.
- R11: After a partial issue, the unissued instruction moves to slot 0 and issues as soon as its hazards clear. pipe_stall is high in every cycle in which the second stage holds an instruction that it does not issue.
- R12: fetch_stall is high when the first stage holds a packet that the second stage cannot take at the next edge. No fetch input is accepted in that cycle. After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_vld | input | 2 | Valid bit per offered slot; bit 0 is the older slot |
| fetch_ins0 | input | 21 | Older offered descriptor |
| fetch_ins1 | input | 21 | Younger offered descriptor |
| fetch_stall | output | 1 | Offered packet is not taken this cycle |
| issue_vld | output | 2 | Issue strobe per slot of the second stage |
| issue_cnt | output | 2 | Number of instructions issued this cycle |
| issue_ins0 | output | 21 | Descriptor in the older issue slot |
| issue_ins1 | output | 21 | Descriptor in the younger issue slot |
| pipe_stall | output | 1 | Second stage holds an instruction it does not issue |

## Verification
A wrong scoreboard count shows directly on issue_vld. A consumer then leaves one or more cycles too early or too late after its producer, and the error shows within the producer's latency of at most three cycles. A wrong split decision in the first stage shows two cycles after acceptance, as a 2'b11 where 2'b01 was due or the other way round. A wrong retention path shows one cycle later, when the wrong descriptor appears on issue_ins0 or the left-behind instruction never appears. A wrong hold in the first stage shows on the following issue as a lost or repeated packet.

// File: rtl/pic_pkg.sv
// Package pic_pkg
// Shared instruction-kind encoding and per-kind decode helpers for the
// dual-issue pair hazard checker. Assumes a 3-bit kind field at the top of
// every descriptor; register fields are sized by the modules' parameters.
package pic_pkg;

    typedef enum logic [2:0] {
        K_INT    = 3'd0,
        K_LOAD   = 3'd1,
        K_STORE  = 3'd2,
        K_BRANCH = 3'd3,
        K_FPOP   = 3'd4,
        K_FLOAD  = 3'd5,
        K_FSTORE = 3'd6,
        K_FMOVE  = 3'd7
    } kind_e;

    localparam int KIND_W = 3;

    // True when the kind reads its first source field.
    function automatic logic reads_a(kind_e k);
        return 1'b1;
    endfunction

    // True when the kind reads its second source field.
    function automatic logic reads_b(kind_e k);
        return (k == K_INT) || (k == K_STORE) || (k == K_BRANCH) ||
               (k == K_FPOP) || (k == K_FSTORE);
    endfunction

    // True when the kind produces a register result.
    function automatic logic writes_dst(kind_e k);
        return (k == K_INT) || (k == K_LOAD) || (k == K_FPOP) ||
               (k == K_FLOAD) || (k == K_FMOVE);
    endfunction

    // True for the floating-point arithmetic slot class.
    function automatic logic is_fp_op(kind_e k);
        return k == K_FPOP;
    endfunction

    // True for integer-side kinds that use floating-point register ports.
    function automatic logic uses_fp_port(kind_e k);
        return (k == K_FLOAD) || (k == K_FSTORE) || (k == K_FMOVE);
    endfunction

endpackage

// File: rtl/pic_pair_stage.sv
// Module pic_pair_stage
// First issue stage. Registers the fetched packet, compacts a lone slot-1
// instruction into slot 0, and decides whether the two members may leave
// together (slot class, floating-point port sharing, in-pair RAW and WAW).
// Assumes the next stage reports through 'advance' whether it can take a
// packet at the coming edge; the packet is held otherwise.
module pic_pair_stage
    import pic_pkg::*;
#(
    parameter int REG_W = 6,
    localparam int IW = KIND_W + 3 * REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    in_vld,
    input  logic [IW-1:0] in_ins0,
    input  logic [IW-1:0] in_ins1,
    input  logic          advance,
    output logic          fetch_stall,
    output logic [1:0]    out_vld,
    output logic [IW-1:0] out_ins0,
    output logic [IW-1:0] out_ins1,
    output logic          out_single
);

    localparam int DST_LO = 2 * REG_W;
    localparam int A_LO   = REG_W;

    logic [1:0]    vld_q;
    logic [IW-1:0] ins0_q;
    logic [IW-1:0] ins1_q;
    logic          held;
    logic          take;

    kind_e            k0, k1;
    logic [REG_W-1:0] d0, d1, a1, b1;
    logic             class_clash, port_clash, raw_clash, waw_clash;

    // Stage occupancy and fetch back-pressure.
    always_comb begin
        held        = |vld_q;
        fetch_stall = held && !advance;
        take        = !fetch_stall;
    end

    // Capture a new packet when the stage is free, compacting a lone slot 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            ins0_q <= '0;
            ins1_q <= '0;
        end else if (take) begin
            if (in_vld == 2'b10) begin
                vld_q  <= 2'b01;
                ins0_q <= in_ins1;
                ins1_q <= '0;
            end else begin
                vld_q  <= in_vld;
                ins0_q <= in_ins0;
                ins1_q <= in_ins1;
            end
        end
    end

    // Field extraction for the in-packet checks.
    always_comb begin
        k0 = kind_e'(ins0_q[IW-1 -: KIND_W]);
        k1 = kind_e'(ins1_q[IW-1 -: KIND_W]);
        d0 = ins0_q[DST_LO +: REG_W];
        d1 = ins1_q[DST_LO +: REG_W];
        a1 = ins1_q[A_LO +: REG_W];
        b1 = ins1_q[0 +: REG_W];
    end

    // In-packet hazard decision: any clash forces single issue.
    always_comb begin
        class_clash = is_fp_op(k0) == is_fp_op(k1);
        port_clash  = (is_fp_op(k0) && uses_fp_port(k1)) ||
                      (is_fp_op(k1) && uses_fp_port(k0));
        raw_clash   = writes_dst(k0) &&
                      ((reads_a(k1) && (a1 == d0)) || (reads_b(k1) && (b1 == d0)));
        waw_clash   = writes_dst(k0) && writes_dst(k1) && (d1 == d0);
        out_single  = (vld_q == 2'b11) &&
                      (class_clash || port_clash || raw_clash || waw_clash);
    end

    // Packet presented to the second stage.
    always_comb begin
        out_vld  = vld_q;
        out_ins0 = ins0_q;
        out_ins1 = ins1_q;
    end

    // R12: a packet held under back-pressure does not change.
    p_hold_on_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> ($stable(vld_q) && $stable(ins0_q) && $stable(ins1_q)));

    // R3: a stored packet never has slot 1 without slot 0.
    p_compact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q != 2'b10);

endmodule

// File: rtl/pic_scoreboard.sv
// Module pic_scoreboard
// Per-register countdown of cycles until an in-flight result is usable.
// A count of zero means the register may be read or overwritten. Each
// register is loaded by at most one issue slot per cycle; the issue stage
// guarantees the two slots never target the same register together.
module pic_scoreboard #(
    parameter int REG_W = 6,
    parameter int CNT_W = 2,
    localparam int NREG = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set0_en,
    input  logic [REG_W-1:0] set0_idx,
    input  logic [CNT_W-1:0] set0_val,
    input  logic             set1_en,
    input  logic [REG_W-1:0] set1_idx,
    input  logic [CNT_W-1:0] set1_val,
    output logic [NREG-1:0]  busy
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [CNT_W-1:0] cnt_q;
        logic             hit0, hit1;

        // Select which issue slot, if any, loads this register.
        always_comb begin
            hit0 = set0_en && (set0_idx == REG_W'(r));
            hit1 = set1_en && (set1_idx == REG_W'(r));
        end

        // Load on issue, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)         cnt_q <= '0;
            else if (hit0)      cnt_q <= set0_val;
            else if (hit1)      cnt_q <= set1_val;
            else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
        end

        assign busy[r] = cnt_q != '0;

        // R9: a register loaded with a nonzero wait reads busy next cycle.
        p_set_marks_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
            ((hit0 && set0_val != 0) || (hit1 && set1_val != 0)) |=> busy[r]);

        // R7: a busy count only decreases unless reloaded.
        p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!hit0 && !hit1 && cnt_q != 0) |=> (cnt_q == $past(cnt_q) - 1'b1));
    end

endmodule

// File: rtl/pic_issue_stage.sv
// Module pic_issue_stage
// Second issue stage. Checks each held instruction against the scoreboard
// (sources and destination), issues in program order, shifts a left-behind
// slot-1 instruction into slot 0, and loads the scoreboard for each issued
// instruction with a multi-cycle result. Assumes the first stage has
// already marked pairs that may not leave together.
module pic_issue_stage
    import pic_pkg::*;
#(
    parameter int REG_W     = 6,
    parameter int CNT_W     = 2,
    parameter int LAT_LOAD  = 2,
    parameter int LAT_FPOP  = 3,
    parameter int LAT_FMOVE = 1,
    localparam int IW   = KIND_W + 3 * REG_W,
    localparam int NREG = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       in_vld,
    input  logic [IW-1:0]    in_ins0,
    input  logic [IW-1:0]    in_ins1,
    input  logic             in_single,
    input  logic [NREG-1:0]  busy,
    output logic             free,
    output logic [1:0]       issue_vld,
    output logic [1:0]       issue_cnt,
    output logic [IW-1:0]    issue_ins0,
    output logic [IW-1:0]    issue_ins1,
    output logic             pipe_stall,
    output logic             set0_en,
    output logic [REG_W-1:0] set0_idx,
    output logic [CNT_W-1:0] set0_val,
    output logic             set1_en,
    output logic [REG_W-1:0] set1_idx,
    output logic [CNT_W-1:0] set1_val
);

    localparam int DST_LO = 2 * REG_W;
    localparam int A_LO   = REG_W;

    logic [1:0]    vld_q;
    logic [IW-1:0] ins0_q;
    logic [IW-1:0] ins1_q;
    logic          single_q;
    logic          rdy0, rdy1, go0, go1, done;

    // Result latency of a kind, in cycles from issue to first use.
    function automatic int lat_of(kind_e k);
        case (k)
            K_LOAD, K_FLOAD: return LAT_LOAD;
            K_FPOP:          return LAT_FPOP;
            K_FMOVE:         return LAT_FMOVE;
            K_INT:           return 1;
            default:         return 0;
        endcase
    endfunction

    // True when no source or destination of the descriptor is pending.
    function automatic logic clear_of(logic [IW-1:0] ins, logic [NREG-1:0] bz);
        kind_e k;
        k = kind_e'(ins[IW-1 -: KIND_W]);
        return !(reads_a(k) && bz[ins[A_LO +: REG_W]]) &&
               !(reads_b(k) && bz[ins[0 +: REG_W]]) &&
               !(writes_dst(k) && bz[ins[DST_LO +: REG_W]]);
    endfunction

    // Scoreboard wait value for an issued descriptor with a multi-cycle result.
    function automatic logic [CNT_W-1:0] wait_of(logic [IW-1:0] ins);
        int l;
        l = lat_of(kind_e'(ins[IW-1 -: KIND_W]));
        return (l > 1) ? CNT_W'(l - 1) : '0;
    endfunction

    // In-order issue decision against in-flight work.
    always_comb begin
        rdy0       = clear_of(ins0_q, busy);
        rdy1       = clear_of(ins1_q, busy);
        go0        = vld_q[0] && rdy0;
        go1        = go0 && vld_q[1] && !single_q && rdy1;
        done       = go0 && (!vld_q[1] || go1);
        free       = (vld_q == 2'b00) || done;
        pipe_stall = (vld_q != 2'b00) && !done;
        issue_vld  = {go1, go0};
        issue_cnt  = {go0 && go1, go0 ^ go1};
        issue_ins0 = ins0_q;
        issue_ins1 = ins1_q;
    end

    // Scoreboard loads for issued producers.
    always_comb begin
        set0_en  = go0 && writes_dst(kind_e'(ins0_q[IW-1 -: KIND_W]));
        set0_idx = ins0_q[DST_LO +: REG_W];
        set0_val = wait_of(ins0_q);
        set1_en  = go1 && writes_dst(kind_e'(ins1_q[IW-1 -: KIND_W]));
        set1_idx = ins1_q[DST_LO +: REG_W];
        set1_val = wait_of(ins1_q);
    end

    // Take a new packet when emptied, shift a left-behind slot 1, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q    <= '0;
            ins0_q   <= '0;
            ins1_q   <= '0;
            single_q <= 1'b0;
        end else if (free) begin
            vld_q    <= in_vld;
            ins0_q   <= in_ins0;
            ins1_q   <= in_ins1;
            single_q <= in_single;
        end else if (go0) begin
            vld_q    <= {1'b0, vld_q[1]};
            ins0_q   <= ins1_q;
            ins1_q   <= '0;
            single_q <= 1'b0;
        end
    end

    // R10: slot 1 never issues ahead of slot 0.
    p_in_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_vld[1] |-> issue_vld[0]);

    // R4: a pair marked by the first stage never leaves in one cycle.
    p_split_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q == 2'b11 && single_q) |-> !issue_vld[1]);

    // R11: after a partial issue the younger instruction becomes the oldest.
    p_leftover_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q == 2'b11 && issue_vld == 2'b01) |=>
            (vld_q == 2'b01 && ins0_q == $past(ins1_q)));

    // R11: a fully blocked stage keeps its contents.
    p_block_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_stall && !issue_vld[0]) |=> ($stable(ins0_q) && $stable(vld_q)));

endmodule

// File: rtl/pair_issue_ctrl.sv
// Module pair_issue_ctrl
// Top of the dual-issue pair hazard checker: first stage (in-packet
// checks), second stage (in-flight checks and issue) and the destination
// scoreboard. Assumes fetch drops its packet when fetch_stall is high and
// offers it again later.
module pair_issue_ctrl
    import pic_pkg::*;
#(
    parameter int REG_W     = 6,
    parameter int LAT_LOAD  = 2,
    parameter int LAT_FPOP  = 3,
    parameter int LAT_FMOVE = 1,
    localparam int IW      = KIND_W + 3 * REG_W,
    localparam int NREG    = 1 << REG_W,
    localparam int LAT_MAX = (LAT_FPOP > LAT_LOAD) ?
                             ((LAT_FPOP > LAT_FMOVE) ? LAT_FPOP : LAT_FMOVE) :
                             ((LAT_LOAD > LAT_FMOVE) ? LAT_LOAD : LAT_FMOVE),
    localparam int CNT_W   = (LAT_MAX > 2) ? $clog2(LAT_MAX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    fetch_vld,
    input  logic [IW-1:0] fetch_ins0,
    input  logic [IW-1:0] fetch_ins1,
    output logic          fetch_stall,
    output logic [1:0]    issue_vld,
    output logic [1:0]    issue_cnt,
    output logic [IW-1:0] issue_ins0,
    output logic [IW-1:0] issue_ins1,
    output logic          pipe_stall
);

    logic [1:0]       s1_vld;
    logic [IW-1:0]    s1_ins0, s1_ins1;
    logic             s1_single;
    logic             s2_free;
    logic [NREG-1:0]  busy;
    logic             set0_en, set1_en;
    logic [REG_W-1:0] set0_idx, set1_idx;
    logic [CNT_W-1:0] set0_val, set1_val;

    pic_pair_stage #(.REG_W(REG_W)) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_vld      (fetch_vld),
        .in_ins0     (fetch_ins0),
        .in_ins1     (fetch_ins1),
        .advance     (s2_free),
        .fetch_stall (fetch_stall),
        .out_vld     (s1_vld),
        .out_ins0    (s1_ins0),
        .out_ins1    (s1_ins1),
        .out_single  (s1_single)
    );

    pic_issue_stage #(
        .REG_W     (REG_W),
        .CNT_W     (CNT_W),
        .LAT_LOAD  (LAT_LOAD),
        .LAT_FPOP  (LAT_FPOP),
        .LAT_FMOVE (LAT_FMOVE)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_vld     (s1_vld),
        .in_ins0    (s1_ins0),
        .in_ins1    (s1_ins1),
        .in_single  (s1_single),
        .busy       (busy),
        .free       (s2_free),
        .issue_vld  (issue_vld),
        .issue_cnt  (issue_cnt),
        .issue_ins0 (issue_ins0),
        .issue_ins1 (issue_ins1),
        .pipe_stall (pipe_stall),
        .set0_en    (set0_en),
        .set0_idx   (set0_idx),
        .set0_val   (set0_val),
        .set1_en    (set1_en),
        .set1_idx   (set1_idx),
        .set1_val   (set1_val)
    );

    pic_scoreboard #(.REG_W(REG_W), .CNT_W(CNT_W)) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set0_en  (set0_en),
        .set0_idx (set0_idx),
        .set0_val (set0_val),
        .set1_en  (set1_en),
        .set1_idx (set1_idx),
        .set1_val (set1_val),
        .busy     (busy)
    );

    // R6: the two issued slots never load the same scoreboard entry.
    p_no_double_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set0_en && set1_en) |-> (set0_idx != set1_idx));

    // R12: back-pressure coincides with a second stage that keeps work.
    p_stall_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |-> pipe_stall);

endmodule

// File: tb/pair_issue_ctrl_tb_top.sv
// Directed bench for pair_issue_ctrl: one task per scenario, each checking
// its own results at the falling edge, cycle counts taken from the brief.
module pair_issue_ctrl_tb_top;

    localparam int IW = 21;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    fetch_vld = '0;
    logic [IW-1:0] fetch_ins0 = '0;
    logic [IW-1:0] fetch_ins1 = '0;
    logic          fetch_stall;
    logic [1:0]    issue_vld;
    logic [1:0]    issue_cnt;
    logic [IW-1:0] issue_ins0;
    logic [IW-1:0] issue_ins1;
    logic          pipe_stall;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    pair_issue_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_vld   (fetch_vld),
        .fetch_ins0  (fetch_ins0),
        .fetch_ins1  (fetch_ins1),
        .fetch_stall (fetch_stall),
        .issue_vld   (issue_vld),
        .issue_cnt   (issue_cnt),
        .issue_ins0  (issue_ins0),
        .issue_ins1  (issue_ins1),
        .pipe_stall  (pipe_stall)
    );

    localparam logic [2:0] KI = 3'd0, KL = 3'd1, KB = 3'd3, KF = 3'd4, KFL = 3'd5;

    function automatic logic [IW-1:0] mk(logic [2:0] k, int d, int a, int b);
        return {k, 6'(d), 6'(a), 6'(b)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic drive(logic [1:0] v, logic [IW-1:0] i0, logic [IW-1:0] i1);
        fetch_vld = v; fetch_ins0 = i0; fetch_ins1 = i1;
    endtask

    task automatic quiet();
        fetch_vld = '0; fetch_ins0 = '0; fetch_ins1 = '0;
        repeat (6) tick();
    endtask

    task automatic t_reset();
        chk("R12 reset issue_vld", 32'(issue_vld), 0);
        chk("R12 reset fetch_stall", 32'(fetch_stall), 0);
        chk("R12 reset pipe_stall", 32'(pipe_stall), 0);
        chk("R12 reset issue_cnt", 32'(issue_cnt), 0);
    endtask

    task automatic t_pair();
        logic [IW-1:0] a = mk(KI, 1, 2, 3), b = mk(KF, 33, 34, 35);
        drive(2'b11, a, b); tick(); drive(0, '0, '0); tick();
        chk("R2 pair issue_vld", 32'(issue_vld), 3);
        chk("R2 pair issue_cnt", 32'(issue_cnt), 2);
        chk("R1 R2 pair slot1 ins", 32'(issue_ins1), 32'(b));
        quiet();
    endtask

    task automatic t_single();
        logic [IW-1:0] a = mk(KB, 0, 4, 5), c = mk(KI, 13, 1, 2);
        drive(2'b01, a, '0); tick(); drive(0, '0, '0); tick();
        chk("R3 single issue_vld", 32'(issue_vld), 1);
        chk("R3 single issue_cnt", 32'(issue_cnt), 1);
        quiet();
        drive(2'b10, '0, c); tick(); drive(0, '0, '0); tick();
        chk("R3 compact issue_vld", 32'(issue_vld), 1);
        chk("R3 compact issue_ins0", 32'(issue_ins0), 32'(c));
        quiet();
    endtask

    task automatic t_port();
        logic [IW-1:0] a = mk(KFL, 40, 1, 0), b = mk(KF, 41, 42, 43);
        drive(2'b11, a, b); tick(); drive(0, '0, '0); tick();
        chk("R5 port first issue_vld", 32'(issue_vld), 1);
        chk("R5 port first ins", 32'(issue_ins0), 32'(a));
        chk("R11 port pipe_stall", 32'(pipe_stall), 1);
        tick();
        chk("R5 R11 port second issue_vld", 32'(issue_vld), 1);
        chk("R11 port leftover ins", 32'(issue_ins0), 32'(b));
        quiet();
    endtask

    task automatic t_class();
        logic [IW-1:0] a = mk(KI, 4, 1, 2), b = mk(KB, 0, 5, 6);
        drive(2'b11, a, b); tick(); drive(0, '0, '0); tick();
        chk("R4 class first issue_vld", 32'(issue_vld), 1);
        tick();
        chk("R4 class second issue_vld", 32'(issue_vld), 1);
        chk("R4 class second ins", 32'(issue_ins0), 32'(b));
        quiet();
    endtask

    task automatic t_pair_dep();
        logic [IW-1:0] a = mk(KF, 50, 33, 34), b = mk(KB, 0, 50, 1);
        logic [IW-1:0] c = mk(KI, 14, 1, 2), d = mk(KF, 14, 33, 34);
        drive(2'b11, a, b); tick(); drive(0, '0, '0); tick();
        chk("R6 raw first issue_vld", 32'(issue_vld), 1);
        tick();
        chk("R8 raw wait1 issue_vld", 32'(issue_vld), 0);
        tick();
        chk("R8 raw wait2 issue_vld", 32'(issue_vld), 0);
        tick();
        chk("R8 raw release issue_vld", 32'(issue_vld), 1);
        chk("R8 raw release ins", 32'(issue_ins0), 32'(b));
        quiet();
        drive(2'b11, c, d); tick(); drive(0, '0, '0); tick();
        chk("R6 waw first issue_vld", 32'(issue_vld), 1);
        tick();
        chk("R6 waw second ins", 32'(issue_ins0), 32'(d));
        chk("R6 waw second issue_vld", 32'(issue_vld), 1);
        quiet();
    endtask

    task automatic t_load_use();
        logic [IW-1:0] a = mk(KL, 9, 1, 0), b = mk(KI, 10, 9, 2);
        drive(2'b01, a, '0); tick(); drive(2'b01, b, '0); tick(); drive(0, '0, '0);
        chk("R7 load issue", 32'(issue_vld), 1);
        tick();
        chk("R7 use blocked", 32'(issue_vld), 0);
        chk("R11 use pipe_stall", 32'(pipe_stall), 1);
        tick();
        chk("R7 use issue_vld", 32'(issue_vld), 1);
        chk("R7 use ins", 32'(issue_ins0), 32'(b));
        quiet();
    endtask

    task automatic t_waw_stall();
        logic [IW-1:0] a = mk(KF, 52, 33, 34), b = mk(KFL, 52, 1, 0), c = mk(KI, 11, 1, 2);
        drive(2'b01, a, '0); tick(); drive(2'b01, b, '0); tick(); drive(2'b01, c, '0);
        chk("R9 producer issue", 32'(issue_vld), 1);
        tick(); drive(0, '0, '0);
        chk("R9 waw blocked 1", 32'(issue_vld), 0);
        chk("R12 fetch_stall held 1", 32'(fetch_stall), 1);
        tick();
        chk("R9 waw blocked 2", 32'(issue_vld), 0);
        chk("R12 fetch_stall held 2", 32'(fetch_stall), 1);
        tick();
        chk("R9 waw release ins", 32'(issue_ins0), 32'(b));
        chk("R9 waw release vld", 32'(issue_vld), 1);
        chk("R12 fetch_stall released", 32'(fetch_stall), 0);
        tick();
        chk("R12 held packet issued", 32'(issue_ins0), 32'(c));
        chk("R12 held packet vld", 32'(issue_vld), 1);
        quiet();
    endtask

    task automatic t_leftover_dep();
        logic [IW-1:0] a = mk(KFL, 60, 1, 0), b = mk(KF, 61, 60, 62);
        drive(2'b11, a, b); tick(); drive(0, '0, '0); tick();
        chk("R11 dep first", 32'(issue_vld), 1);
        tick();
        chk("R11 dep leftover blocked", 32'(issue_vld), 0);
        tick();
        chk("R11 dep leftover issue", 32'(issue_vld), 1);
        chk("R11 dep leftover ins", 32'(issue_ins0), 32'(b));
        quiet();
    endtask

    task automatic t_in_order();
        logic [IW-1:0] x = mk(KF, 63, 33, 34);
        logic [IW-1:0] y0 = mk(KI, 12, 63, 1), y1 = mk(KF, 35, 36, 37);
        drive(2'b01, x, '0); tick(); drive(2'b11, y0, y1); tick(); drive(0, '0, '0);
        chk("R10 producer", 32'(issue_vld), 1);
        tick();
        chk("R10 blocked 1", 32'(issue_vld), 0);
        tick();
        chk("R10 blocked 2", 32'(issue_vld), 0);
        tick();
        chk("R10 both issue", 32'(issue_vld), 3);
        chk("R10 both cnt", 32'(issue_cnt), 2);
        quiet();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_pair();
        t_single();
        t_port();
        t_class();
        t_pair_dep();
        t_load_use();
        t_waw_stall();
        t_leftover_dep();
        t_in_order();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule